// File: doc/BRIEF.md
# Configurable UART Frame Engine

A full-duplex asynchronous serial transmitter and receiver whose character format is chosen by a five-bit format register. The format selects 7- or 8-bit characters, one or two transmitted stop bits, the order in which data bits go onto the line, and one of four parity behaviours. An external generator supplies a single-cycle tick at sixteen times the bit rate. Both directions use that tick to time their bits.

Characters enter through a valid/ready transmit port and leave through a valid/ready receive port. Three control inputs gate the unit: power, transmit enable and receive enable. The format register is writable only while the unit is unpowered, or while both directions are disabled. Each received character comes with parity-error, framing-error and overrun flags. The line idles high. Every frame starts with one low start bit.

Top module: `uart_frame_engine`

## Requirements
- R1: Format bit 0 selects 7 data bits (0) or 8 data bits (1). In 7-bit mode the transmitter ignores bit 7 of the written data, and bit 7 of every delivered character is 0.
- R2: Format bit 1 selects one stop bit (0) or two stop bits (1) for transmitted frames. The transmitter stays busy for exactly the frame's bit count times 16 ticks.
- R3: Format bit 2 selects the data bit order: 0 sends and receives the most significant data bit first, and 1 sends and receives the least significant data bit first.
- R4: Format bits 4:3 set the transmitted parity bit, which follows the last data bit: 00 sends no parity bit, 01 sends a constant 0, 10 makes the count of ones in data plus parity odd, and 11 makes it even.
- R5: With format bits 4:3 set to 10 or 11, the receiver raises err_parity for a character whose parity bit breaks the selected odd or even rule. With 00 it expects no parity bit.
- R6: With format bits 4:3 set to 01, the receiver takes in a parity bit but never raises err_parity, whatever value that bit has.
- R7: A format write takes effect only while pwr_on is 0, or while both tx_on and rx_on are 0. Any other write leaves fmt_q unchanged.
- R8: The receiver samples every bit at its middle. A start bit that is high again at its middle is discarded, and no character is produced.
- R9: The receiver examines only the first stop bit. err_frame is set for a character whose first stop bit is sampled low. A low second stop bit is not flagged.
- R10: A character that completes while rx_valid is high and rx_ready is low replaces the held character and sets err_overrun. All three error flags are reloaded whenever a character completes.
- R11: tx_ready is high only while powered, transmit-enabled and idle. A character is accepted on a cycle where tx_valid and tx_ready are both high. rx_valid stays high with stable data until a cycle where rx_ready is high.
- R12: After reset, txd is high, tx_ready, rx_valid and all flags are low, and fmt_q is 5'b00101 (8 bits, one stop bit, least significant bit first, no parity).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| pwr_on | input | 1 | Unit power enable |
| tx_on | input | 1 | Transmit enable |
| rx_on | input | 1 | Receive enable |
| fmt_wr | input | 1 | Format register write strobe |
| fmt_wdata | input | 5 | Format value: [0] 8-bit, [1] two stop bits, [2] LSB first, [4:3] parity mode |
| fmt_q | output | 5 | Current format |
| tx_data | input | 8 | Character to send |
| tx_valid | input | 1 | tx_data is valid |
| tx_ready | output | 1 | Transmitter can accept a character |
| txd | output | 1 | Serial output |
| rxd | input | 1 | Serial input |
| rx_data | output | 8 | Received character |
| rx_valid | output | 1 | rx_data holds an unread character |
| rx_ready | input | 1 | Consumer takes rx_data |
| err_parity | output | 1 | Parity error for the held character |
| err_frame | output | 1 | First stop bit was low |
| err_overrun | output | 1 | Previous character was overwritten |

## Verification
A bad transmit shift register or bit counter shows on txd within one bit time (64 clocks at the bench tick rate). It also appears as a wrong busy length when tx_ready returns. A receiver that loses bit alignment delivers a wrong character or wrong flags one cycle after the first stop bit's middle. A start detector that is too eager produces a character where none was sent. A format register that ignores the lock changes fmt_q on the cycle after the write.

// File: rtl/ufe_pkg.sv
package ufe_pkg;

   localparam int CHAR_W  = 8;
   localparam int FRAME_W = 12;

   typedef enum logic [1:0] {
      PAR_NONE = 2'b00,
      PAR_ZERO = 2'b01,
      PAR_ODD  = 2'b10,
      PAR_EVEN = 2'b11
   } par_e;

   typedef struct packed {
      par_e par;
      logic lsb_first;
      logic stop2;
      logic char8;
   } fmt_t;

   function automatic logic par_bit(par_e p, logic [CHAR_W-1:0] d);
      case (p)
         PAR_ODD:  return ~^d;
         PAR_EVEN: return ^d;
         default:  return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/ufe_fmt_reg.sv
module ufe_fmt_reg
   import ufe_pkg::*;
#(
   parameter logic [4:0] RESET_FMT = 5'b00101
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [4:0] wdata,
   input  logic       pwr,
   input  logic       tx_en,
   input  logic       rx_en,
   output fmt_t       fmt
);
   logic unlocked;
   assign unlocked = !pwr || (!tx_en && !rx_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               fmt <= fmt_t'(RESET_FMT);
      else if (wr && unlocked)  fmt <= fmt_t'(wdata);
   end
endmodule

// File: rtl/ufe_tx.sv
module ufe_tx
   import ufe_pkg::*;
#(
   parameter int OS = 16
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              tick,
   input  fmt_t              fmt,
   input  logic [CHAR_W-1:0] data,
   input  logic              valid,
   output logic              ready,
   output logic              txd
);
   localparam int CW = $clog2(OS);
   localparam logic [CW-1:0] LAST = CW'(OS - 1);

   logic               busy;
   logic [FRAME_W-1:0] shreg;
   logic [3:0]         left;
   logic [CW-1:0]      tc;

   logic [FRAME_W-1:0] fb;
   logic [3:0]         flen;
   logic [CHAR_W-1:0]  dm;

   always_comb begin
      int nd;
      int pos;
      nd = fmt.char8 ? 8 : 7;
      dm = fmt.char8 ? data : {1'b0, data[6:0]};
      fb = '1;
      fb[0] = 1'b0;
      for (int i = 0; i < CHAR_W; i++) begin
         if (i < nd) begin
            if (fmt.lsb_first) fb[1+i] = dm[i];
            else               fb[1+i] = dm[nd-1-i];
         end
      end
      pos = 1 + nd;
      if (fmt.par != PAR_NONE) begin
         fb[pos] = par_bit(fmt.par, dm);
         pos = pos + 1;
      end
      flen = 4'(pos + (fmt.stop2 ? 2 : 1));
   end

   assign ready = active && !busy;
   assign txd   = busy ? shreg[0] : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         shreg <= '1;
         left  <= '0;
         tc    <= '0;
      end else if (!active) begin
         busy <= 1'b0;
      end else if (!busy) begin
         if (valid) begin
            busy  <= 1'b1;
            shreg <= fb;
            left  <= flen;
            tc    <= '0;
         end
      end else if (tick) begin
         if (tc == LAST) begin
            tc    <= '0;
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            left  <= left - 4'd1;
            if (left == 4'd1) busy <= 1'b0;
         end else begin
            tc <= tc + 1'b1;
         end
      end
   end
endmodule

// File: rtl/ufe_rx.sv
module ufe_rx
   import ufe_pkg::*;
#(
   parameter int OS   = 16,
   parameter int SYNC = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              active,
   input  logic              tick,
   input  logic              rxd,
   input  logic              char8,
   input  logic              lsb_first,
   input  par_e              par,
   input  logic              rd,
   output logic [CHAR_W-1:0] data,
   output logic              valid,
   output logic              pe,
   output logic              fe,
   output logic              oe,
   output logic              done
);
   localparam int CW = $clog2(OS);
   localparam logic [CW-1:0] MID  = CW'(OS/2 - 1);
   localparam logic [CW-1:0] LAST = CW'(OS - 1);

   typedef enum logic [1:0] {S_IDLE, S_START, S_BITS, S_STOP} st_e;

   logic line;

   generate
      if (SYNC == 0) begin : g_nosync
         assign line = rxd;
      end else if (SYNC == 1) begin : g_sync1
         logic s0;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) s0 <= 1'b1; else s0 <= rxd;
         assign line = s0;
      end else begin : g_syncn
         logic [SYNC-1:0] sc;
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sc <= '1; else sc <= {sc[SYNC-2:0], rxd};
         assign line = sc[SYNC-1];
      end
   endgenerate

   st_e           st;
   logic [CW-1:0] tc;
   logic [3:0]    idx;
   logic [8:0]    raw;
   logic          stop_low;

   logic [3:0]        nd;
   logic [3:0]        nexp;
   logic [CHAR_W-1:0] dec;
   logic              pbit;
   logic              perr;

   assign nd   = char8 ? 4'd8 : 4'd7;
   assign nexp = nd + ((par != PAR_NONE) ? 4'd1 : 4'd0);
   assign pbit = raw[nd];

   always_comb begin
      dec = '0;
      for (int i = 0; i < CHAR_W; i++) begin
         if (i < int'(nd)) begin
            if (lsb_first) dec[i] = raw[i];
            else           dec[i] = raw[int'(nd)-1-i];
         end
      end
      perr = ((par == PAR_ODD)  && !(^{dec, pbit})) ||
             ((par == PAR_EVEN) &&  (^{dec, pbit}));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         tc       <= '0;
         idx      <= '0;
         raw      <= '0;
         stop_low <= 1'b0;
         done     <= 1'b0;
      end else begin
         done <= 1'b0;
         if (!active) begin
            st <= S_IDLE;
         end else begin
            case (st)
               S_IDLE: begin
                  tc <= '0;
                  if (!line) st <= S_START;
               end
               S_START: if (tick) begin
                  if (tc == MID) begin
                     tc  <= '0;
                     idx <= '0;
                     st  <= line ? S_IDLE : S_BITS;
                  end else tc <= tc + 1'b1;
               end
               S_BITS: if (tick) begin
                  if (tc == LAST) begin
                     tc       <= '0;
                     raw[idx] <= line;
                     if (idx == nexp - 4'd1) st <= S_STOP;
                     else                    idx <= idx + 4'd1;
                  end else tc <= tc + 1'b1;
               end
               default: if (tick) begin
                  if (tc == LAST) begin
                     tc       <= '0;
                     stop_low <= !line;
                     done     <= 1'b1;
                     st       <= S_IDLE;
                  end else tc <= tc + 1'b1;
               end
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data  <= '0;
         valid <= 1'b0;
         pe    <= 1'b0;
         fe    <= 1'b0;
         oe    <= 1'b0;
      end else if (done) begin
         data  <= dec;
         valid <= 1'b1;
         pe    <= perr;
         fe    <= stop_low;
         oe    <= valid && !rd;
      end else if (rd) begin
         valid <= 1'b0;
      end
   end
endmodule

// File: rtl/uart_frame_engine.sv
module uart_frame_engine
   import ufe_pkg::*;
#(
   parameter int         OS        = 16,
   parameter int         SYNC      = 2,
   parameter logic [4:0] RESET_FMT = 5'b00101
)(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       baud_tick,
   input  logic       pwr_on,
   input  logic       tx_on,
   input  logic       rx_on,
   input  logic       fmt_wr,
   input  logic [4:0] fmt_wdata,
   output logic [4:0] fmt_q,
   input  logic [7:0] tx_data,
   input  logic       tx_valid,
   output logic       tx_ready,
   output logic       txd,
   input  logic       rxd,
   output logic [7:0] rx_data,
   output logic       rx_valid,
   input  logic       rx_ready,
   output logic       err_parity,
   output logic       err_frame,
   output logic       err_overrun
);
   generate
      if (OS < 4 || (OS % 2) != 0) begin : g_bad_os
         $error("OS must be an even value of at least 4");
      end
      if (SYNC < 0 || SYNC > 4) begin : g_bad_sync
         $error("SYNC must lie between 0 and 4");
      end
   endgenerate

   fmt_t fmt;
   logic rx_done;

   ufe_fmt_reg #(.RESET_FMT(RESET_FMT)) u_fmt (
      .clk(clk), .rst_n(rst_n), .wr(fmt_wr), .wdata(fmt_wdata),
      .pwr(pwr_on), .tx_en(tx_on), .rx_en(rx_on), .fmt(fmt)
   );

   ufe_tx #(.OS(OS)) u_tx (
      .clk(clk), .rst_n(rst_n), .active(pwr_on && tx_on), .tick(baud_tick),
      .fmt(fmt), .data(tx_data), .valid(tx_valid), .ready(tx_ready), .txd(txd)
   );

   ufe_rx #(.OS(OS), .SYNC(SYNC)) u_rx (
      .clk(clk), .rst_n(rst_n), .active(pwr_on && rx_on), .tick(baud_tick),
      .rxd(rxd), .char8(fmt.char8), .lsb_first(fmt.lsb_first), .par(fmt.par),
      .rd(rx_ready), .data(rx_data), .valid(rx_valid), .pe(err_parity),
      .fe(err_frame), .oe(err_overrun), .done(rx_done)
   );

   assign fmt_q = fmt;
endmodule

// File: rtl/ufe_checker.sv
module ufe_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       pwr_on,
   input logic       tx_on,
   input logic       rx_on,
   input logic       fmt_wr,
   input logic [4:0] fmt_q,
   input logic       tx_valid,
   input logic       tx_ready,
   input logic       txd,
   input logic [7:0] rx_data,
   input logic       rx_valid,
   input logic       rx_ready,
   input logic       err_parity,
   input logic       err_overrun,
   input logic       rx_done
);
   assert_fmt_locked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      fmt_wr && pwr_on && (tx_on || rx_on) |=> $stable(fmt_q));

   assert_idle_line_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_ready |-> txd);

   assert_busy_after_accept_R11: assert property (@(posedge clk) disable iff (!rst_n)
      tx_valid && tx_ready |=> !tx_ready);

   assert_rx_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid && !rx_ready && !rx_done |=> rx_valid && $stable(rx_data));

   assert_zero_par_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done && fmt_q[4:3] == 2'b01 |=> !err_parity);

   assert_char7_top_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done && !fmt_q[0] |=> !rx_data[7]);

   assert_overrun_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_done && rx_valid && !rx_ready |=> err_overrun);
endmodule

bind uart_frame_engine ufe_checker chk_i (
   .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .tx_on(tx_on), .rx_on(rx_on),
   .fmt_wr(fmt_wr), .fmt_q(fmt_q), .tx_valid(tx_valid), .tx_ready(tx_ready),
   .txd(txd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
   .err_parity(err_parity), .err_overrun(err_overrun), .rx_done(rx_done)
);

// File: tb/uart_frame_engine_tb_top.sv
`timescale 1ns/1ps
module uart_frame_engine_tb_top;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic baud_tick = 1'b0;
   logic pwr_on = 1'b0, tx_on = 1'b0, rx_on = 1'b0;
   logic fmt_wr = 1'b0;
   logic [4:0] fmt_wdata = '0;
   logic [4:0] fmt_q;
   logic [7:0] tx_data = '0;
   logic tx_valid = 1'b0;
   logic tx_ready, txd;
   logic [7:0] rx_data;
   logic rx_valid, err_parity, err_frame, err_overrun;
   logic rx_ready = 1'b0;
   logic loop_mode = 1'b1;
   logic line = 1'b1;
   logic hold_rx = 1'b0;
   logic rxd;
   logic [4:0] cur_fmt = 5'b00101;

   int total = 0;
   int bad = 0;
   bit finished = 0;
   logic [10:0] q[$];

   assign rxd = loop_mode ? txd : line;

   always #2 clk = ~clk;

   uart_frame_engine dut_i (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .pwr_on(pwr_on),
      .tx_on(tx_on), .rx_on(rx_on), .fmt_wr(fmt_wr), .fmt_wdata(fmt_wdata),
      .fmt_q(fmt_q), .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
      .txd(txd), .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid),
      .rx_ready(rx_ready), .err_parity(err_parity), .err_frame(err_frame),
      .err_overrun(err_overrun)
   );

   initial begin
      int c = 0;
      forever begin
         @(negedge clk);
         c = (c + 1) % 4;
         baud_tick = (c == 0);
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic void make_frame(input logic [4:0] f, input logic [7:0] d,
                                      output logic [11:0] fr, output int n);
      int nd;
      int pos;
      logic [7:0] dm;
      nd = f[0] ? 8 : 7;
      dm = f[0] ? d : {1'b0, d[6:0]};
      fr = '1;
      fr[0] = 1'b0;
      for (int i = 0; i < nd; i++) fr[1+i] = f[2] ? dm[i] : dm[nd-1-i];
      pos = 1 + nd;
      if (f[4:3] != 2'b00) begin
         fr[pos] = (f[4:3] == 2'b01) ? 1'b0 : (f[4:3] == 2'b10) ? ~^dm : ^dm;
         pos++;
      end
      n = pos + (f[1] ? 2 : 1);
   endfunction

   // scoreboard monitor: data, parity, framing, overrun
   initial begin
      forever begin
         @(negedge clk);
         rx_ready = 1'b0;
         if (rx_valid && !hold_rx && rst_n) begin
            if (q.size() == 0) begin
               chk(1'b0, "R8 unexpected character", {21'd0, rx_data, err_parity, err_frame, err_overrun}, 0);
            end else begin
               logic [10:0] e;
               logic [10:0] g;
               e = q.pop_front();
               g = {rx_data, err_parity, err_frame, err_overrun};
               chk(g == e, "R5/R9/R10 rx item", {21'd0, g}, {21'd0, e});
            end
            rx_ready = 1'b1;
         end
      end
   end

   task automatic set_fmt(input logic [4:0] f);
      @(negedge clk);
      tx_on = 1'b0; rx_on = 1'b0;
      fmt_wr = 1'b1; fmt_wdata = f;
      @(negedge clk);
      fmt_wr = 1'b0; tx_on = 1'b1; rx_on = 1'b1;
      cur_fmt = f;
   endtask

   task automatic tx_send(input logic [7:0] d);
      logic [11:0] fr;
      logic [11:0] got;
      logic [7:0] dm;
      int n;
      int cnt;
      make_frame(cur_fmt, d, fr, n);
      dm = cur_fmt[0] ? d : {1'b0, d[6:0]};
      q.push_back({dm, 3'b000});
      @(negedge clk);
      tx_data = d; tx_valid = 1'b1;
      while (!tx_ready) @(negedge clk);
      @(posedge clk);
      @(negedge clk);
      tx_valid = 1'b0;
      got = '1;
      repeat (31) @(negedge clk);
      got[0] = txd;
      for (int k = 1; k < n; k++) begin
         repeat (64) @(negedge clk);
         got[k] = txd;
      end
      // R1 R2 R3 R4: whole line frame
      chk(got == fr, "R1/R2/R3/R4 tx frame", {20'd0, got}, {20'd0, fr});
      cnt = 31 + (n - 1) * 64;
      while (!tx_ready) begin @(negedge clk); cnt++; end
      chk(cnt >= n*64 - 8 && cnt <= n*64 + 8, "R2 busy length", cnt, n*64);
   endtask

   task automatic rx_line(input logic [11:0] fr, input int n, input bit short_last);
      loop_mode = 1'b0;
      for (int k = 0; k < n; k++) begin
         line = fr[k];
         repeat ((k == n - 1 && short_last) ? 48 : 64) @(negedge clk);
      end
      line = 1'b1;
      repeat (128) @(negedge clk);
   endtask

   task automatic drain();
      int w = 0;
      while (q.size() != 0 && w < 2000) begin @(negedge clk); w++; end
      repeat (4) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         chk(1'b0, "R11 watchdog", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [11:0] fr;
      int n;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      chk(txd == 1'b1, "R12 txd idle", txd, 1);
      chk(!rx_valid && !tx_ready, "R12 handshakes low", {rx_valid, tx_ready}, 0);
      chk({err_parity, err_frame, err_overrun} == 3'b000, "R12 flags", {err_parity, err_frame, err_overrun}, 0);
      chk(fmt_q == 5'b00101, "R12 format", fmt_q, 5'b00101);

      // R7 format lock
      pwr_on = 1'b1; tx_on = 1'b1;
      fmt_wr = 1'b1; fmt_wdata = 5'b11010;
      @(negedge clk); fmt_wr = 1'b0; @(negedge clk);
      chk(fmt_q == 5'b00101, "R7 locked write ignored", fmt_q, 5'b00101);
      tx_on = 1'b0; rx_on = 1'b1;
      fmt_wr = 1'b1; fmt_wdata = 5'b11011;
      @(negedge clk); fmt_wr = 1'b0; @(negedge clk);
      chk(fmt_q == 5'b00101, "R7 rx enable locks", fmt_q, 5'b00101);
      rx_on = 1'b0;
      fmt_wr = 1'b1; fmt_wdata = 5'b11010;
      @(negedge clk); fmt_wr = 1'b0; @(negedge clk);
      chk(fmt_q == 5'b11010, "R7 write with both disabled", fmt_q, 5'b11010);
      pwr_on = 1'b0; tx_on = 1'b1; rx_on = 1'b1;
      fmt_wr = 1'b1; fmt_wdata = 5'b00101;
      @(negedge clk); fmt_wr = 1'b0; @(negedge clk);
      chk(fmt_q == 5'b00101, "R7 write while unpowered", fmt_q, 5'b00101);

      // R11 ready gating
      pwr_on = 1'b1; tx_on = 1'b0; rx_on = 1'b1;
      @(negedge clk);
      chk(!tx_ready, "R11 ready low when tx disabled", tx_ready, 0);
      tx_on = 1'b1;
      @(negedge clk);
      chk(tx_ready, "R11 ready high when idle", tx_ready, 1);

      // loopback over every format
      loop_mode = 1'b1;
      for (int f = 0; f < 32; f++) begin
         set_fmt(5'(f));
         tx_send(8'h96 + 8'(f * 23));
         tx_send(~(8'h96 + 8'(f * 23)));
         drain();
      end

      // R3 order on the receive side
      set_fmt(5'b00001);
      q.push_back({8'h80, 3'b000});
      rx_line(12'hE02, 10, 0);
      drain();
      set_fmt(5'b00101);
      q.push_back({8'h01, 3'b000});
      rx_line(12'hE02, 10, 0);
      drain();
      // R1 seven-bit receive
      set_fmt(5'b00100);
      q.push_back({8'h7F, 3'b000});
      rx_line(12'hFFE, 9, 0);
      drain();

      // R5 parity checks
      set_fmt(5'b10101);
      make_frame(5'b10101, 8'h5A, fr, n);
      fr[9] = ~fr[9];
      q.push_back({8'h5A, 3'b100});
      rx_line(fr, n, 0);
      drain();
      set_fmt(5'b11101);
      make_frame(5'b11101, 8'hC3, fr, n);
      q.push_back({8'hC3, 3'b000});
      rx_line(fr, n, 0);
      fr[9] = ~fr[9];
      q.push_back({8'hC3, 3'b100});
      rx_line(fr, n, 0);
      drain();
      // R6 zero-parity receive never flags
      set_fmt(5'b01101);
      make_frame(5'b01101, 8'h07, fr, n);
      fr[9] = 1'b1;
      q.push_back({8'h07, 3'b000});
      rx_line(fr, n, 0);
      drain();

      // R9 framing
      set_fmt(5'b00101);
      make_frame(5'b00101, 8'h3C, fr, n);
      fr[9] = 1'b0;
      q.push_back({8'h3C, 3'b010});
      rx_line(fr, n, 1);
      drain();
      set_fmt(5'b00111);
      make_frame(5'b00111, 8'h3C, fr, n);
      fr[10] = 1'b0;
      q.push_back({8'h3C, 3'b000});
      rx_line(fr, n, 1);
      drain();

      // R8 short start pulse
      set_fmt(5'b00101);
      loop_mode = 1'b0;
      line = 1'b0;
      repeat (20) @(negedge clk);
      line = 1'b1;
      repeat (1200) @(negedge clk);
      chk(!rx_valid && q.size() == 0, "R8 glitch rejected", rx_valid, 0);

      // R10 overrun
      hold_rx = 1'b1;
      make_frame(5'b00101, 8'h11, fr, n);
      rx_line(fr, n, 0);
      make_frame(5'b00101, 8'h22, fr, n);
      rx_line(fr, n, 0);
      chk(rx_valid && rx_data == 8'h22 && err_overrun, "R10 overrun overwrite",
          {rx_valid, rx_data, err_overrun}, {1'b1, 8'h22, 1'b1});
      q.push_back({8'h22, 3'b001});
      hold_rx = 1'b0;
      drain();
      make_frame(5'b00101, 8'h33, fr, n);
      q.push_back({8'h33, 3'b000});
      rx_line(fr, n, 0);
      drain();

      chk(q.size() == 0, "R11 scoreboard empty", q.size(), 0);
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule